// File: doc/BRIEF.md
# Multi-Port Hardware Semaphore Bank

A bank of lock gates shared by several bus masters, each master attached on its own write/read port. A gate is a byte-wide register. A master takes a free gate by writing its own tag, which is its port index plus one, so a tag of zero always stands for "unlocked". The bank stores that tag next to the domain identifier that came with the write. Reading the gate returns both fields, so the master can see whether it won the lock. Only the owner can hand the gate back, by writing a zero tag.

One extra register, one address above the last gate, clears gates. It acts only after a two-write key sequence. The second write names either a single gate or, with an out-of-range number, the whole bank. While the first key is held and the sequence is waiting for its second write, the register reads back nonzero. Any other write breaks the sequence. Reads are combinational from the current state, so a write made in one cycle is visible on every port in the next cycle.

Top module: `sema_bank`

## Requirements
- R1: A write from port p to a free gate whose data bits [3:0] equal p+1 claims it. A nonzero value other than p+1 from that port is ignored.
- R2: A held gate reads back with the owner tag in bits [3:0], the claiming write's domain in bits [7:4], and zeros in bits [15:8].
- R3: A free gate reads back as all zeros, including its domain field.
- R4: A claim write to a gate held by another master leaves the gate unchanged.
- R5: Writing tag 0 to a gate frees it only when the writer's port index plus one equals the stored tag. A zero write from any other port is ignored.
- R6: When several ports claim the same free gate in one cycle, the lowest-index port becomes owner.
- R7: Only the lowest-index writing port of a cycle is seen by the reset sequencer. A write of 0xE2 in bits [7:0] to address N_GATES arms it.
- R8: While armed, a write of 0x1D in bits [7:0] to address N_GATES fires the reset. A gate number in bits [15:8] below N_GATES frees only that gate; a larger number frees all gates. The sequencer then returns to idle.
- R9: Address N_GATES reads 1 while the sequencer is armed and 0 while it is idle.
- R10: While armed, any write that is not the firing write returns the sequencer to idle with no gate freed. A later 0x1D write seen while idle has no effect.
- R11: After hardware reset every gate is free and the sequencer is idle.
- R12: Addresses above N_GATES read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | N_PORTS | Write strobe, one bit per port |
| addr_i | input | N_PORTS*AW | Register address per port (gates 0..N_GATES-1, reset register at N_GATES) |
| wdata_i | input | N_PORTS*16 | Write data per port |
| dom_i | input | N_PORTS*4 | Domain identifier of the master on each port |
| rdata_o | output | N_PORTS*16 | Combinational read data per port for addr_i |

## Verification
A corrupted owner tag or a domain field that survives a release shows up on the very next cycle as a wrong readback byte for that gate on any port. A stuck or mis-advanced key sequencer shows at once in the reset register's status bit. It also shows one cycle after the firing write, when gates that should be free still read as held, or the reverse. Wrong arbitration appears as a readback naming the higher-index contender in the cycle after a simultaneous claim.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int TAG_W = 4;
  localparam int DOM_W = 4;
  localparam int DW    = 16;
  localparam int KEY_W = 8;
  localparam int GN_W  = 8;
  localparam logic [KEY_W-1:0] KEY_ARM  = 8'hE2;
  localparam logic [KEY_W-1:0] KEY_FIRE = 8'h1D;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_state_e;
endpackage

// File: rtl/sema_gate.sv
module sema_gate
  import sema_pkg::*;
#(
  parameter int N_PORTS = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_PORTS-1:0]               claim_i,
  input  logic [N_PORTS-1:0]               rel_i,
  input  logic [N_PORTS-1:0][DOM_W-1:0]    dom_i,
  input  logic                             clr_i,
  output logic [TAG_W-1:0]                 tag_o,
  output logic [DOM_W-1:0]                 dom_o
);
  logic [TAG_W-1:0] tag_q, tag_d, win_tag;
  logic [DOM_W-1:0] dom_q, dom_d, win_dom;
  logic             win, own_rel;

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    win     = 1'b0;
    win_tag = '0;
    win_dom = '0;
    for (int p = N_PORTS - 1; p >= 0; p--) begin
      if (claim_i[p]) begin
        win     = 1'b1;
        win_tag = TAG_W'(p + 1);
        win_dom = dom_i[p];
      end
    end
  end

  always_comb begin
    own_rel = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (rel_i[p] && tag_q == TAG_W'(p + 1)) own_rel = 1'b1;
    end
  end

  always_comb begin
    tag_d = tag_q;
    dom_d = dom_q;
    if (clr_i || own_rel) begin
      tag_d = '0;
      dom_d = '0;
    end else if (tag_q == '0 && win) begin
      tag_d = win_tag;
      dom_d = win_dom;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      dom_q <= '0;
    end else begin
      tag_q <= tag_d;
      dom_q <= dom_d;
    end
  end

  assign tag_o = tag_q;
  assign dom_o = dom_q;
endmodule

// File: rtl/sema_rst_seq.sv
module sema_rst_seq
  import sema_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int N_GATES = 16,
  parameter int AW      = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_PORTS-1:0]            wr_en_i,
  input  logic [N_PORTS-1:0][AW-1:0]    addr_i,
  input  logic [N_PORTS-1:0][DW-1:0]    wdata_i,
  output logic                          armed_o,
  output logic [N_GATES-1:0]            clr_o
);
  localparam logic [AW-1:0] RST_ADDR = AW'(N_GATES);

  seq_state_e       st_q, st_d;
  logic             any_wr, hit, fire;
  logic [AW-1:0]    w_addr;
  logic [DW-1:0]    w_data;
  logic [KEY_W-1:0] w_key;
  logic [GN_W-1:0]  w_gn;

  always_comb begin
    w_addr = '0;
    w_data = '0;
    for (int p = N_PORTS - 1; p >= 0; p--) begin
      if (wr_en_i[p]) begin
        w_addr = addr_i[p];
        w_data = wdata_i[p];
      end
    end
  end

  assign any_wr = |wr_en_i;
  assign w_key  = w_data[KEY_W-1:0];
  assign w_gn   = w_data[KEY_W +: GN_W];
  assign hit    = any_wr && (w_addr == RST_ADDR);
  assign fire   = (st_q == SEQ_ARMED) && hit && (w_key == KEY_FIRE);

  always_comb begin
    st_d = st_q;
    if (any_wr) begin
      if (st_q == SEQ_IDLE) st_d = (hit && w_key == KEY_ARM) ? SEQ_ARMED : SEQ_IDLE;
      else                  st_d = SEQ_IDLE;
    end
  end

  generate
    for (genvar g = 0; g < N_GATES; g++) begin : g_clr
      assign clr_o[g] = fire && ((w_gn >= GN_W'(N_GATES)) || (w_gn == GN_W'(g)));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == SEQ_ARMED);
endmodule

// File: rtl/sema_rd_mux.sv
module sema_rd_mux
  import sema_pkg::*;
#(
  parameter int N_GATES = 16,
  parameter int AW      = 5
) (
  input  logic [AW-1:0]                 addr_i,
  input  logic [N_GATES-1:0][TAG_W-1:0] tag_i,
  input  logic [N_GATES-1:0][DOM_W-1:0] dom_i,
  input  logic                          armed_i,
  output logic [DW-1:0]                 rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(N_GATES)) begin
      rdata_o[0] = armed_i;
    end else begin
      for (int g = 0; g < N_GATES; g++) begin
        if (addr_i == AW'(g)) rdata_o = DW'({dom_i[g], tag_i[g]});
      end
    end
  end
endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int N_GATES = 16,
  parameter int AW      = $clog2(N_GATES + 2)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_PORTS-1:0]            wr_en_i,
  input  logic [N_PORTS-1:0][AW-1:0]    addr_i,
  input  logic [N_PORTS-1:0][DW-1:0]    wdata_i,
  input  logic [N_PORTS-1:0][DOM_W-1:0] dom_i,
  output logic [N_PORTS-1:0][DW-1:0]    rdata_o
);
  logic [N_GATES-1:0][N_PORTS-1:0] claim_m, rel_m;
  logic [N_GATES-1:0][TAG_W-1:0]   gate_tag;
  logic [N_GATES-1:0][DOM_W-1:0]   gate_dom;
  logic [N_GATES-1:0]              clr_mask;
  logic                            armed;

  generate
    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_dec
        logic sel;
        assign sel           = wr_en_i[p] && (addr_i[p] == AW'(g));
        assign claim_m[g][p] = sel && (wdata_i[p][TAG_W-1:0] == TAG_W'(p + 1));
        assign rel_m[g][p]   = sel && (wdata_i[p][TAG_W-1:0] == '0);
      end
      sema_gate #(.N_PORTS(N_PORTS)) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .claim_i(claim_m[g]),
        .rel_i  (rel_m[g]),
        .dom_i  (dom_i),
        .clr_i  (clr_mask[g]),
        .tag_o  (gate_tag[g]),
        .dom_o  (gate_dom[g])
      );
    end
  endgenerate

  sema_rst_seq #(.N_PORTS(N_PORTS), .N_GATES(N_GATES), .AW(AW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .armed_o(armed),
    .clr_o  (clr_mask)
  );

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
      sema_rd_mux #(.N_GATES(N_GATES), .AW(AW)) u_rd (
        .addr_i (addr_i[p]),
        .tag_i  (gate_tag),
        .dom_i  (gate_dom),
        .armed_i(armed),
        .rdata_o(rdata_o[p])
      );
    end
  endgenerate
endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk
  import sema_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int N_GATES = 16,
  parameter int AW      = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_PORTS-1:0]            wr_en_i,
  input logic [N_PORTS-1:0][AW-1:0]    addr_i,
  input logic [N_PORTS-1:0][DW-1:0]    wdata_i,
  input logic [N_GATES-1:0][TAG_W-1:0] gate_tag,
  input logic [N_GATES-1:0][DOM_W-1:0] gate_dom,
  input logic [N_GATES-1:0]            clr_mask,
  input logic                          armed
);
  AST_CLR_ONLY_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_mask) |-> armed); // R8
  AST_CLR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_mask) || (&clr_mask)); // R8
  AST_SEQ_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && (|wr_en_i)) |=> !armed); // R10

  generate
    for (genvar g = 0; g < N_GATES; g++) begin : g_chk
      AST_TAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_tag[g] <= TAG_W'(N_PORTS)); // R1
      AST_FREE_NO_DOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_tag[g] == '0) |-> (gate_dom[g] == '0)); // R3
      AST_OWNER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_tag[g] != '0 && !clr_mask[g]) |=> (gate_tag[g] == $past(gate_tag[g]) || gate_tag[g] == '0)); // R4
      AST_PORT0_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i[0] && addr_i[0] == AW'(g) && wdata_i[0][TAG_W-1:0] == TAG_W'(1)
         && gate_tag[g] == '0 && !clr_mask[g]) |=> (gate_tag[g] == TAG_W'(1))); // R6
    end
  endgenerate
endmodule

bind sema_bank sema_bank_chk #(.N_PORTS(N_PORTS), .N_GATES(N_GATES), .AW(AW)) u_chk (.*);

// File: tb/tb_sema_bank.sv
module tb_sema_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NG = 16;
  localparam int AW = $clog2(NG + 2);
  localparam int RA = NG;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0]        wr_en = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][15:0]  wdata = '0;
  logic [NP-1:0][3:0]   dom = '0;
  logic [NP-1:0][15:0]  rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {int p; logic [15:0] exp; string rq;} item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_bank #(.N_PORTS(NP), .N_GATES(NG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .dom_i(dom), .rdata_o(rdata)
  );

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (rdata[it.p] !== it.exp) begin
        n_fail++;
        $display("FAIL %s: port %0d got %h expected %h", it.rq, it.p, rdata[it.p], it.exp);
      end
    end
  end

  function automatic logic [15:0] gb(input logic [3:0] d, input logic [3:0] t);
    return {8'h00, d, t};
  endfunction

  task automatic rd(input int p, input int a, input logic [15:0] exp, input string rq);
    @(posedge clk); #1;
    wr_en = '0;
    addr[p] = AW'(a);
    q.push_back('{p: p, exp: exp, rq: rq});
    @(negedge clk); #1;
  endtask

  task automatic pulse();
    @(posedge clk); #1;
    wr_en = '0;
  endtask

  task automatic wr(input int p, input int a, input logic [15:0] d, input logic [3:0] dm);
    @(posedge clk); #1;
    wr_en = '0;
    wr_en[p] = 1'b1; addr[p] = AW'(a); wdata[p] = d; dom[p] = dm;
    pulse();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 / R3 reset state
    for (int g = 0; g < NG; g++) rd(g % NP, g, 16'h0, "R11 gate free after reset");
    rd(0, RA, 16'h0, "R11 R9 sequencer idle after reset");

    // R1 R2 claim
    wr(1, 3, 16'h0002, 4'h5);
    rd(0, 3, gb(4'h5, 4'h2), "R1 R2 claim gate3 by port1");
    wr(2, 4, 16'h0001, 4'h7);
    rd(2, 4, 16'h0, "R1 wrong tag ignored");
    wr(2, 4, 16'hFF03, 4'h7);
    rd(1, 4, gb(4'h7, 4'h3), "R2 upper data bits not stored");
    // R4 foreign claim
    wr(0, 3, 16'h0001, 4'h9);
    rd(2, 3, gb(4'h5, 4'h2), "R4 held gate unchanged");
    // R5 release
    wr(0, 3, 16'h0000, 4'h0);
    rd(1, 3, gb(4'h5, 4'h2), "R5 non-owner release ignored");
    wr(1, 3, 16'h0000, 4'h0);
    rd(0, 3, 16'h0, "R5 R3 owner release frees gate");

    // R6 simultaneous claims
    @(posedge clk); #1;
    wr_en = '1;
    addr[0] = 7; wdata[0] = 16'h1; dom[0] = 4'h1;
    addr[1] = 7; wdata[1] = 16'h2; dom[1] = 4'h2;
    addr[2] = 7; wdata[2] = 16'h3; dom[2] = 4'h3;
    pulse();
    rd(2, 7, gb(4'h1, 4'h1), "R6 lowest port wins");
    @(posedge clk); #1;
    wr_en = 3'b110;
    addr[1] = 8; wdata[1] = 16'h2; dom[1] = 4'h6;
    addr[2] = 8; wdata[2] = 16'h3; dom[2] = 4'h4;
    pulse();
    rd(0, 8, gb(4'h6, 4'h2), "R6 port1 beats port2");

    // single gate reset
    wr(2, 0, 16'h3, 4'hA);
    wr(2, 9, 16'h3, 4'hA);
    wr(2, 15, 16'h3, 4'hA);
    wr(0, RA, 16'h00E2, 4'h0);
    rd(1, RA, 16'h0001, "R7 R9 armed after key one");
    rd(1, RA, 16'h0001, "R9 stays armed across reads");
    wr(0, RA, 16'h091D, 4'h0);
    rd(0, 9, 16'h0, "R8 named gate freed");
    rd(0, 0, gb(4'hA, 4'h3), "R8 other gate kept");
    rd(0, 15, gb(4'hA, 4'h3), "R8 other gate kept");
    rd(2, RA, 16'h0, "R8 R9 idle after fire");

    // R10 aborts
    wr(0, RA, 16'h00E2, 4'h0);
    wr(0, RA, 16'h0055, 4'h0);
    rd(1, RA, 16'h0, "R10 wrong key aborts");
    rd(1, 0, gb(4'hA, 4'h3), "R10 no gate freed on wrong key");
    wr(1, RA, 16'h00E2, 4'h0);
    wr(1, 10, 16'h0002, 4'hC);
    rd(0, RA, 16'h0, "R10 other write aborts");
    wr(1, RA, 16'h001D, 4'h0);
    rd(0, 0, gb(4'hA, 4'h3), "R10 second key while idle ignored");
    rd(0, 10, gb(4'hC, 4'h2), "R10 breaking write still takes effect");

    // R7 priority of writers
    @(posedge clk); #1;
    wr_en = 3'b011;
    addr[0] = 11; wdata[0] = 16'h1; dom[0] = 4'h2;
    addr[1] = RA; wdata[1] = 16'h00E2;
    pulse();
    rd(2, RA, 16'h0, "R7 lower-priority key not seen");
    rd(2, 11, gb(4'h2, 4'h1), "R7 higher-priority gate write taken");

    // R8 reset all
    wr(2, RA, 16'h00E2, 4'h0);
    wr(2, RA, 16'hFF1D, 4'h0);
    rd(0, 0, 16'h0, "R8 all gates freed");
    rd(0, 7, 16'h0, "R8 all gates freed");
    rd(1, 10, 16'h0, "R8 all gates freed");
    rd(2, 15, 16'h0, "R8 all gates freed");

    // R12 out of range
    wr(0, 20, 16'h0001, 4'h3);
    rd(0, 20, 16'h0, "R12 out-of-range reads zero");
    rd(0, RA, 16'h0, "R12 out-of-range write did not arm");

    @(posedge clk);
    done = 1'b1;
    report();
  end
endmodule